// File: doc/BRIEF.md
# Background ECC Scrubber

This block sweeps a SEC-DED protected memory through its own access port. It reads every word in turn and checks it with an extended Hamming code. A word with one flipped bit is repaired and written back. A word with two flipped bits is reported and left untouched. Repairing single-bit errors promptly keeps a second upset in the same word from turning a correctable error into an uncorrectable one.

The sweep handles one word per slot. Between slots the block waits a programmable number of cycles, so software controls how much memory bandwidth scrubbing takes. The foreground path always has priority. While `fg_req` is high the scrubber offers nothing on its port and keeps the same address for later.

If a foreground access happens after the scrubber has read a word but before its repair is written, the repaired copy may be stale. In that case the scrubber discards the repair and reads the word again.

The memory port uses valid/ready. A request stays offered, unchanged, until `mem_ready` accepts it or `fg_req` takes the port. Read data returns on `mem_rvalid` and cannot be back-pressured.

Top module: `ecc_scrubber`

## Requirements
- R1: Codeword layout. Bits 1..N are Hamming positions: check bits sit at the powers of two, and the data bits fill the remaining positions from data bit 0 upward. Bit 0 makes the parity of the whole codeword even. For 32 data bits, N is 38 and the codeword is 39 bits.
- R2: Reads visit addresses in ascending order from 0 after reset and wrap after the last word. A read is repeated only when R7 or R9 forces a retry. `pass_done` pulses for exactly one cycle after the last word is finished.
- R3: For consecutive clean words, read acceptances are `cfg_interval` + 4 cycles apart.
- R4: A word with a single data-bit error is written back in corrected form, and `corr_cnt` increases by one.
- R5: A single error in a check bit, or in the overall parity bit 0, is corrected and counted in the same way as a data-bit error.
- R6: A word with two flipped bits is not written. `uncorr_cnt` increases by one, and `last_ue_addr` takes its address.
- R7: `mem_valid` is low in every cycle in which `fg_req` is high. After a lost slot the scrubber offers the same address again.
- R8: While `mem_valid` is high and `mem_ready` is low, `mem_addr`, `mem_we` and `mem_wdata` stay stable.
- R9: If `fg_req` is high between a read's acceptance and its writeback, the repair is dropped and the address is read again. Only the result of that fresh read is acted on.
- R10: `corr_cnt` and `uncorr_cnt` saturate at their maximum value.
- R11: After reset, both counters, `last_ue_addr` and `pass_done` are zero, and `mem_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_interval | input | IVL_W | Idle cycles between scrub slots |
| fg_req | input | 1 | Foreground owns the memory this cycle |
| mem_valid | output | 1 | Scrubber request offered |
| mem_ready | input | 1 | Memory accepts the offered request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | CW_W | Corrected codeword to write |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | CW_W | Read codeword |
| corr_cnt | output | CNT_W | Saturating count of corrected words |
| uncorr_cnt | output | CNT_W | Saturating count of uncorrectable words |
| last_ue_addr | output | ADDR_W | Address of the latest uncorrectable word |
| pass_done | output | 1 | One-cycle pulse at the end of each pass |

## Verification
The hardest case to reach is a foreground access that lands in the two or three cycles between a read of a corrupted word and its writeback. A long slot interval makes the target read easy to spot. The bench waits for the read of that address to be offered, then raises `fg_req` for one cycle right after acceptance while replacing the word with a new clean value. The bench then checks that no stale repair reached memory and that no correction was counted.

// File: rtl/scrub_pkg.sv
package scrub_pkg;

  typedef enum logic [2:0] {
    ST_WAIT,
    ST_RD,
    ST_RESP,
    ST_EVAL,
    ST_WR
  } scrub_st_e;

  // number of Hamming check bits for a given data width
  function automatic int chk_bits(input int dw);
    int p;
    p = 1;
    while ((1 << p) < dw + p + 1) p++;
    return p;
  endfunction

endpackage

// File: rtl/secded_check.sv
module secded_check #(
  parameter int CW_W  = 39,
  parameter int SYN_W = 6
) (
  input  logic [CW_W-1:0] cw_in,
  output logic            is_clean,
  output logic            is_sec,
  output logic            is_ded,
  output logic [CW_W-1:0] cw_fixed
);
  logic [SYN_W-1:0] syn;
  logic             par;

  always_comb begin
    syn = '0;
    for (int i = 1; i < CW_W; i++) begin
      if (cw_in[i]) syn = syn ^ SYN_W'(i);
    end
    par      = ^cw_in;
    is_clean = (syn == '0) && !par;
    // odd parity: one flip, located by the syndrome (0 = overall parity bit)
    is_sec   = par && (int'(syn) < CW_W);
    is_ded   = !is_clean && !is_sec;
    cw_fixed = cw_in;
    if (is_sec) cw_fixed[syn] = ~cw_in[syn];
  end

endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] MAXV = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (inc && cnt != MAXV) cnt <= cnt + 1'b1;
  end

  assert_sat_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == MAXV) |=> (cnt == MAXV));

endmodule

// File: rtl/slot_timer.sv
module slot_timer #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic         expired
);
  logic [W-1:0] cnt;

  assign expired = run && (cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!run)     cnt <= '0;
    else if (!expired) cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/ecc_scrubber.sv
module ecc_scrubber
  import scrub_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int IVL_W  = 12,
  parameter int CNT_W  = 8,
  localparam int PAR_W = chk_bits(DATA_W),
  localparam int CW_W  = DATA_W + PAR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IVL_W-1:0]  cfg_interval,
  input  logic              fg_req,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [CW_W-1:0]   mem_wdata,
  input  logic              mem_rvalid,
  input  logic [CW_W-1:0]   mem_rdata,
  output logic [CNT_W-1:0]  corr_cnt,
  output logic [CNT_W-1:0]  uncorr_cnt,
  output logic [ADDR_W-1:0] last_ue_addr,
  output logic              pass_done
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

  scrub_st_e         st, st_nxt;
  logic [ADDR_W-1:0] cur_addr;
  logic [CW_W-1:0]   rd_cw, wr_cw, fix_cw;
  logic              fg_seen, fire, advance, tmr_exp;
  logic              w_clean, w_sec, w_ded;
  logic [1:0]        ev_inc;
  logic [CNT_W-1:0]  ev_cnt [2];

  slot_timer #(.W(IVL_W)) u_tmr (
    .clk, .rst_n,
    .run(st == ST_WAIT),
    .limit(cfg_interval),
    .expired(tmr_exp)
  );

  secded_check #(.CW_W(CW_W), .SYN_W(PAR_W)) u_dec (
    .cw_in(rd_cw),
    .is_clean(w_clean),
    .is_sec(w_sec),
    .is_ded(w_ded),
    .cw_fixed(fix_cw)
  );

  // port drive: foreground wins unconditionally
  assign mem_valid = !fg_req && ((st == ST_RD) || (st == ST_WR && !fg_seen));
  assign mem_we    = (st == ST_WR);
  assign mem_addr  = cur_addr;
  assign mem_wdata = wr_cw;
  assign fire      = mem_valid && mem_ready;
  assign advance   = (st == ST_EVAL && !w_sec) || (st == ST_WR && fire);

  always_comb begin
    st_nxt = st;
    case (st)
      ST_WAIT: if (tmr_exp)    st_nxt = ST_RD;
      ST_RD:   if (fire)       st_nxt = ST_RESP;
      ST_RESP: if (mem_rvalid) st_nxt = ST_EVAL;
      ST_EVAL: st_nxt = w_sec ? ST_WR : ST_WAIT;
      ST_WR: begin
        if (fg_seen)   st_nxt = ST_RD;
        else if (fire) st_nxt = ST_WAIT;
      end
      default: st_nxt = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= ST_WAIT;
      cur_addr     <= '0;
      rd_cw        <= '0;
      wr_cw        <= '0;
      fg_seen      <= 1'b0;
      pass_done    <= 1'b0;
      last_ue_addr <= '0;
    end else begin
      st        <= st_nxt;
      pass_done <= advance && (cur_addr == LAST_ADDR);
      if (advance) cur_addr <= cur_addr + 1'b1;
      if (st == ST_RESP && mem_rvalid) rd_cw <= mem_rdata;
      if (st == ST_EVAL) wr_cw <= fix_cw;
      if (st == ST_EVAL && w_ded) last_ue_addr <= cur_addr;
      if (st == ST_RD) fg_seen <= 1'b0;
      else if (fg_req && st != ST_WAIT) fg_seen <= 1'b1;
    end
  end

  assign ev_inc[0] = (st == ST_WR) && fire;
  assign ev_inc[1] = (st == ST_EVAL) && w_ded;

  for (genvar g = 0; g < 2; g++) begin : g_cnt
    sat_counter #(.W(CNT_W)) u_cnt (
      .clk, .rst_n,
      .inc(ev_inc[g]),
      .cnt(ev_cnt[g])
    );
  end

  assign corr_cnt   = ev_cnt[0];
  assign uncorr_cnt = ev_cnt[1];

  assert_fg_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fg_req |-> !mem_valid);

  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=>
      ($stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pass_done |-> (cur_addr == '0));

  assert_ded_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_EVAL && w_ded) |=> (st == ST_WAIT));

  assert_stale_reread_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WR && fg_seen) |=> (st == ST_RD));

  assert_slot_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT && !tmr_exp) |=> (st == ST_WAIT));

endmodule

// File: tb/sim_ecc_scrubber.sv
module sim_ecc_scrubber;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32, AW = 4, IW = 12, CW = 2;
  localparam int CWW = 39, DEPTH = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [IW-1:0] cfg_interval = '0;
  logic fg_req = 1'b0, mem_ready = 1'b1;
  logic mem_valid, mem_we, mem_rvalid = 1'b0, pass_done;
  logic [AW-1:0] mem_addr, last_ue_addr;
  logic [CWW-1:0] mem_wdata, mem_rdata = '0;
  logic [CW-1:0] corr_cnt, uncorr_cnt;

  logic poke_en = 1'b0;
  logic [AW-1:0] poke_addr = '0;
  logic [CWW-1:0] poke_data = '0;
  logic [CWW-1:0] mem [DEPTH];

  int cyc = 0, rd_total = 0, wr_total = 0, pass_cnt = 0, gap = 0, last_rd_cyc = 0;
  int order_err = 0, fg_viol = 0, pd_double = 0;
  logic [AW-1:0] last_rd_addr = '1;
  logic prev_pd = 1'b0;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_scrubber #(.DATA_W(DW), .ADDR_W(AW), .IVL_W(IW), .CNT_W(CW)) u0 (
    .clk, .rst_n, .cfg_interval, .fg_req, .mem_valid, .mem_ready, .mem_we,
    .mem_addr, .mem_wdata, .mem_rvalid, .mem_rdata, .corr_cnt, .uncorr_cnt,
    .last_ue_addr, .pass_done
  );

  // memory model and monitors
  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_rvalid <= 1'b0;
    prev_pd <= pass_done;
    if (poke_en) mem[poke_addr] <= poke_data;
    if (!rst_n) last_rd_addr <= '1;
    if (fg_req && mem_valid) fg_viol <= fg_viol + 1;
    if (pass_done) pass_cnt <= pass_cnt + 1;
    if (pass_done && prev_pd) pd_double <= pd_double + 1;
    if (rst_n && mem_valid && mem_ready) begin
      if (mem_we) begin
        mem[mem_addr] <= mem_wdata;
        wr_total <= wr_total + 1;
      end else begin
        mem_rvalid <= 1'b1;
        mem_rdata <= mem[mem_addr];
        rd_total <= rd_total + 1;
        gap <= cyc - last_rd_cyc;
        last_rd_cyc <= cyc;
        if (mem_addr != last_rd_addr && mem_addr != last_rd_addr + 1'b1)
          order_err <= order_err + 1;
        last_rd_addr <= mem_addr;
      end
    end
  end

  function automatic logic [CWW-1:0] enc(input logic [DW-1:0] d);
    logic [CWW-1:0] c;
    int k;
    c = '0;
    k = 0;
    for (int j = 1; j < CWW; j++)
      if ((j & (j - 1)) != 0) begin c[j] = d[k]; k++; end
    for (int p = 0; p < 6; p++) begin
      logic x;
      x = 1'b0;
      for (int j = 1; j < CWW; j++)
        if (((j >> p) & 1) == 1 && j != (1 << p)) x = x ^ c[j];
      c[1 << p] = x;
    end
    c[0] = ^c[CWW-1:1];
    return c;
  endfunction

  function automatic logic [DW-1:0] pat(input int a);
    return 32'hA5C3_0000 ^ (32'(a) * 32'h0101_1357);
  endfunction

  function automatic logic [CWW-1:0] flip(input logic [CWW-1:0] c, input int b);
    return c ^ (39'd1 << b);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic poke(input int a, input logic [CWW-1:0] v);
    @(negedge clk);
    poke_en = 1'b1; poke_addr = AW'(a); poke_data = v;
    @(negedge clk);
    poke_en = 1'b0;
  endtask

  task automatic hold_reset_load(input logic [IW-1:0] ivl);
    @(negedge clk);
    rst_n = 1'b0; fg_req = 1'b0; mem_ready = 1'b1; cfg_interval = ivl;
    for (int a = 0; a < DEPTH; a++) poke(a, enc(pat(a)));
  endtask

  task automatic release_and_wait(input int passes);
    int tgt;
    @(negedge clk);
    rst_n = 1'b1;
    tgt = pass_cnt + passes;
    while (pass_cnt < tgt) @(negedge clk);
  endtask

  task automatic t_reset;
    hold_reset_load(12'd50);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(corr_cnt == 0 && uncorr_cnt == 0, "R11 counters", 64'({corr_cnt, uncorr_cnt}), 64'd0);
    check(last_ue_addr == 0 && !pass_done, "R11 status", 64'({last_ue_addr, pass_done}), 64'd0);
    check(!mem_valid, "R11 mem_valid", 64'(mem_valid), 64'd0);
  endtask

  task automatic t_clean;
    int w0, oe0;
    bit same;
    hold_reset_load(12'd0);
    w0 = wr_total; oe0 = order_err;
    release_and_wait(2);
    same = 1'b1;
    for (int a = 0; a < DEPTH; a++) if (mem[a] != enc(pat(a))) same = 1'b0;
    check(wr_total == w0 && same, "R1 clean words untouched", 64'(wr_total - w0), 64'd0);
    check(order_err == oe0, "R2 ascending scan", 64'(order_err - oe0), 64'd0);
    check(pd_double == 0 && pass_cnt > 0, "R2 pass_done single pulse", 64'(pd_double), 64'd0);
    check(gap == 4, "R3 gap at interval 0", 64'(gap), 64'd4);
  endtask

  task automatic t_interval;
    hold_reset_load(12'd5);
    release_and_wait(1);
    check(gap == 9, "R3 gap at interval 5", 64'(gap), 64'd9);
  endtask

  task automatic t_single;
    int w0;
    hold_reset_load(12'd0);
    poke(3, flip(enc(pat(3)), 5));
    poke(10, flip(enc(pat(10)), 38));
    w0 = wr_total;
    release_and_wait(1);
    check(mem[3] == enc(pat(3)), "R4 data bit 5 fixed", 64'(mem[3]), 64'(enc(pat(3))));
    check(mem[10] == enc(pat(10)), "R4 data bit 38 fixed", 64'(mem[10]), 64'(enc(pat(10))));
    check(corr_cnt == 2 && wr_total - w0 == 2, "R4 corrected count", 64'(corr_cnt), 64'd2);
  endtask

  task automatic t_checkbit;
    hold_reset_load(12'd2);
    poke(0, flip(enc(pat(0)), 0));
    poke(9, flip(enc(pat(9)), 16));
    release_and_wait(1);
    check(mem[0] == enc(pat(0)), "R5 overall parity fixed", 64'(mem[0]), 64'(enc(pat(0))));
    check(mem[9] == enc(pat(9)), "R5 check bit 16 fixed", 64'(mem[9]), 64'(enc(pat(9))));
    check(corr_cnt == 2, "R5 corrected count", 64'(corr_cnt), 64'd2);
  endtask

  task automatic t_double;
    int w0;
    logic [CWW-1:0] b7, b12;
    hold_reset_load(12'd0);
    b7 = flip(flip(enc(pat(7)), 5), 9);
    b12 = flip(flip(enc(pat(12)), 0), 20);
    poke(7, b7);
    poke(12, b12);
    w0 = wr_total;
    release_and_wait(1);
    check(mem[7] == b7 && mem[12] == b12, "R6 no writeback", 64'(mem[7]), 64'(b7));
    check(wr_total == w0, "R6 write count", 64'(wr_total - w0), 64'd0);
    check(uncorr_cnt == 2 && corr_cnt == 0, "R6 uncorrectable count", 64'(uncorr_cnt), 64'd2);
    check(last_ue_addr == 12, "R6 last address", 64'(last_ue_addr), 64'd12);
  endtask

  task automatic t_saturate;
    hold_reset_load(12'd0);
    for (int a = 0; a < 4; a++) poke(a, flip(enc(pat(a)), 7 + a));
    for (int a = 8; a < 12; a++) poke(a, flip(flip(enc(pat(a)), 3), 6));
    release_and_wait(1);
    check(corr_cnt == 2'd3, "R10 corrected saturates", 64'(corr_cnt), 64'd3);
    check(uncorr_cnt == 2'd3 && last_ue_addr == 11, "R10 uncorrectable saturates",
          64'(uncorr_cnt), 64'd3);
  endtask

  task automatic t_foreground;
    int r0, v0;
    logic [AW-1:0] held;
    hold_reset_load(12'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (9) @(negedge clk);
    while (!(mem_valid && !mem_we)) @(negedge clk);
    held = mem_addr;
    fg_req = 1'b1;
    r0 = rd_total; v0 = fg_viol;
    repeat (30) @(negedge clk);
    check(rd_total == r0 && fg_viol == v0, "R7 no access under foreground",
          64'(rd_total - r0), 64'd0);
    fg_req = 1'b0; mem_ready = 1'b0;
    repeat (10) @(negedge clk);
    check(rd_total == r0 && mem_valid && mem_addr == held, "R8 held under back-pressure",
          64'(mem_addr), 64'(held));
    mem_ready = 1'b1;
    while (rd_total == r0) @(negedge clk);
    check(last_rd_addr == held, "R7 same address retried", 64'(last_rd_addr), 64'(held));
  endtask

  task automatic t_race;
    int w0;
    logic [CWW-1:0] fresh;
    hold_reset_load(12'd20);
    poke(2, flip(enc(pat(2)), 11));
    fresh = enc(32'h1234_5678);
    w0 = wr_total;
    @(negedge clk);
    rst_n = 1'b1;
    while (!(mem_valid && !mem_we && mem_addr == 2)) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    fg_req = 1'b1; poke_en = 1'b1; poke_addr = 2; poke_data = fresh;
    @(negedge clk);
    fg_req = 1'b0; poke_en = 1'b0;
    while (pass_cnt == 0 || !(last_rd_addr == 4'd15)) @(negedge clk);
    repeat (6) @(negedge clk);
    check(mem[2] == fresh, "R9 foreground data kept", 64'(mem[2]), 64'(fresh));
    check(corr_cnt == 0 && wr_total == w0, "R9 stale repair dropped", 64'(corr_cnt), 64'd0);
  endtask

  initial begin
    t_reset();
    t_clean();
    t_interval();
    t_single();
    t_checkbit();
    t_double();
    t_saturate();
    t_foreground();
    t_race();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule